// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block is the command front end of a word-wide parallel NOR flash, built around a small on-chip word array. A host drives chip-select, write-strobe and read-strobe lines, an address bus and a 16-bit data bus. Bus writes are not stored directly. A sequencer matches them against multi-write unlock patterns and turns a completed pattern into one of four things: a word program, a sector erase, entry into a short two-write program mode, or a pause or resume of a running erase.

Program and erase run as timed internal jobs whose lengths are set by cycle-count parameters. While a job runs, the ready line is held low and reads return a status word rather than array data. When the job ends, normal reads come back and new commands are accepted.

An erase works in three steps. It first drives every word of the target sector to zero, then waits out a timed interval, then fills the sector with ones. It can be paused so the host can read or program other sectors in the meantime. A write-protect input shields one end sector from all program and erase commands.

Top module: `norflash_cmd`

## Requirements
- R1: Reset, a synchronous active-high input, aborts any program or erase and clears the command sequencer. `rdy` is high on the next cycle and reads return array data. A word whose program was aborted keeps its old value. The array holds 16'hFFFF in every word from power-up.
- R2: A program is four writes: 8'hAA to word 0x555, 8'h55 to word 0x2AA, 8'hA0 to 0x555, then the target address with the data. The unlock addresses are compared on the low ADDR_W bits. Command codes are taken from `din[7:0]` only.
- R3: `rdy` goes low within three cycles of the write that launches an operation. It stays low while the operation runs and returns high when the operation ends. After that, reads return array data.
- R4: While busy, a read returns a status word. Bit 7 is the complement of bit 7 of the word being written: for a program that is the data, for an erase it is 1. Bit 6 flips on every new read. All other bits are 0.
- R5: An erase is six writes: AA@0x555, 55@0x2AA, 80@0x555, AA@0x555, 55@0x2AA, then 8'h30 to any word of the sector. The sector is selected by the top SECT_W address bits. The sector ends at 16'hFFFF and other sectors are unchanged.
- R6: Writing AA@0x555, 55@0x2AA, 20@0x555 enters a fast mode in which each program takes two writes: 8'hA0 at any address, then address and data. A write of 8'hF0 while the sequencer is idle leaves that mode, after which a lone A0 has no effect.
- R7: Writing 8'hB0 during an erase pauses it and `rdy` returns high. While paused, other sectors can be read and programmed. A program aimed at the paused sector is dropped. Writing 8'h30 resumes the erase, which then completes.
- R8: With `wp_n` low, sector 0 (the last sector when WP_LAST=1) is protected. Program, erase and fast-mode program commands aimed at it are dropped and `rdy` stays high. With `wp_n` high the sector programs normally.
- R9: A write that does not fit the next step of a sequence returns the sequencer to idle and has no effect on the array.
- R10: While an operation is busy, every write except an erase pause is ignored.
- R11: Programming only clears bits: the new word equals the old word AND the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, aborts operations |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low; a write is taken on its first low cycle |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data / command code |
| dout | output | 16 | Read data or status word, registered |
| wp_n | input | 1 | Write protect for one end sector, active low |
| rdy | output | 1 | High when ready, low while an operation runs |

## Verification
Two things can happen in the same cycle: a pause request arriving during a running erase, and that erase's own stepping through its internal work. The bench provokes this by issuing a pause write as soon as `rdy` drops for an erase. It then confirms that `rdy` rises, that reads and programs of another sector during the pause match an arithmetic model, and that after resume the whole array matches the model with the erased sector at all ones. A second overlap, a full program sequence written while another program is busy, is judged by reading back both target words.

// File: rtl/norflash_pkg.sv
package norflash_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM, ST_ES1, ST_ES2, ST_ES3, ST_BPGM
  } cmd_step_t;

  typedef enum logic [1:0] {EP_PRE, EP_WAIT, EP_CLR} ers_phase_t;

  localparam logic [7:0]  CB_UNLK1 = 8'hAA;
  localparam logic [7:0]  CB_UNLK2 = 8'h55;
  localparam logic [7:0]  CB_PROG  = 8'hA0;
  localparam logic [7:0]  CB_ESET  = 8'h80;
  localparam logic [7:0]  CB_SECT  = 8'h30;
  localparam logic [7:0]  CB_BYP   = 8'h20;
  localparam logic [7:0]  CB_SUSP  = 8'hB0;
  localparam logic [7:0]  CB_RES   = 8'h30;
  localparam logic [7:0]  CB_RST   = 8'hF0;
  localparam logic [11:0] UADDR1   = 12'h555;
  localparam logic [11:0] UADDR2   = 12'h2AA;
endpackage

// File: rtl/norflash_array.sv
module norflash_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // erased state at power-up
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  // single port, read-before-write
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd <= mem[addr];
  end
endmodule

// File: rtl/norflash_decode.sv
module norflash_decode
  import norflash_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int SECT_W  = 2,
  parameter bit WP_LAST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              ers_run,
  input  logic              susp,
  input  logic [SECT_W-1:0] esect,
  output logic              go_prog,
  output logic              go_erase,
  output logic              go_susp,
  output logic              go_resume,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [15:0]       cmd_data
);
  localparam logic [ADDR_W-1:0] AD1 = ADDR_W'(UADDR1);
  localparam logic [ADDR_W-1:0] AD2 = ADDR_W'(UADDR2);

  logic [SECT_W-1:0] psect;
  generate
    if (WP_LAST) begin : g_prot_top
      assign psect = '1;
    end else begin : g_prot_bot
      assign psect = '0;
    end
  endgenerate

  cmd_step_t   step;
  logic        byp;
  logic [7:0]  cb;
  logic        prot_hit;
  logic        in_esect;

  assign cb       = din[7:0];
  assign prot_hit = !wp_n && (addr[ADDR_W-1 -: SECT_W] == psect);
  assign in_esect = susp && (addr[ADDR_W-1 -: SECT_W] == esect);

  always_ff @(posedge clk) begin
    go_prog   <= 1'b0;
    go_erase  <= 1'b0;
    go_susp   <= 1'b0;
    go_resume <= 1'b0;
    if (rst) begin
      step     <= ST_IDLE;
      byp      <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else if (wr_evt) begin
      if (busy) begin
        if (ers_run && cb == CB_SUSP) go_susp <= 1'b1;
      end else begin
        step <= ST_IDLE;
        case (step)
          ST_IDLE: begin
            if (cb == CB_UNLK1 && addr == AD1) step <= ST_UNL1;
            else if (cb == CB_RST) byp <= 1'b0;
            else if (byp && cb == CB_PROG) step <= ST_BPGM;
            else if (susp && cb == CB_RES) go_resume <= 1'b1;
          end
          ST_UNL1: begin
            if (cb == CB_UNLK2 && addr == AD2) step <= ST_UNL2;
          end
          ST_UNL2: begin
            if (addr == AD1) begin
              if (cb == CB_PROG) step <= ST_PGM;
              else if (cb == CB_ESET && !susp && !byp) step <= ST_ES1;
              else if (cb == CB_BYP && !susp) byp <= 1'b1;
            end
          end
          ST_PGM, ST_BPGM: begin
            if (!prot_hit && !in_esect) begin
              go_prog  <= 1'b1;
              cmd_addr <= addr;
              cmd_data <= din;
            end
          end
          ST_ES1: begin
            if (cb == CB_UNLK1 && addr == AD1) step <= ST_ES2;
          end
          ST_ES2: begin
            if (cb == CB_UNLK2 && addr == AD2) step <= ST_ES3;
          end
          ST_ES3: begin
            if (cb == CB_SECT && !prot_hit) begin
              go_erase <= 1'b1;
              cmd_addr <= addr;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/norflash_engine.sv
module norflash_engine
  import norflash_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_prog,
  input  logic              go_erase,
  input  logic              go_susp,
  input  logic              go_resume,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_data,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              rd_evt,
  input  logic [15:0]       mem_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [15:0]       mem_wd,
  output logic              busy,
  output logic              ers_run,
  output logic              susp,
  output logic              prog_act,
  output logic              erase_act,
  output logic [SECT_W-1:0] esect,
  output logic [15:0]       status
);
  localparam int IW   = ADDR_W - SECT_W;
  localparam int CMAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] PCNT_INIT = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] ECNT_INIT = CW'(ERASE_CYC - 1);
  localparam logic [IW-1:0] IDX_LAST  = '1;

  logic [CW-1:0]     pcnt, ecnt;
  logic [IW-1:0]     idx;
  ers_phase_t        ph;
  logic [ADDR_W-1:0] op_addr;
  logic [15:0]       op_data;
  logic              tog;
  logic              exp7;
  logic              ers_done;

  assign ers_run  = erase_act && !susp;
  assign busy     = prog_act || ers_run;
  assign ers_done = ers_run && ph == EP_CLR && idx == IDX_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_act  <= 1'b0;
      erase_act <= 1'b0;
      susp      <= 1'b0;
      pcnt      <= '0;
      ecnt      <= '0;
      idx       <= '0;
      ph        <= EP_PRE;
      op_addr   <= '0;
      op_data   <= '0;
      esect     <= '0;
      tog       <= 1'b0;
    end else begin
      if (rd_evt && busy) tog <= ~tog;

      if (go_prog) begin
        prog_act <= 1'b1;
        op_addr  <= cmd_addr;
        op_data  <= cmd_data;
        pcnt     <= PCNT_INIT;
      end else if (prog_act) begin
        if (pcnt == '0) prog_act <= 1'b0;
        else pcnt <= pcnt - 1'b1;
      end

      if (go_erase) begin
        erase_act <= 1'b1;
        esect     <= cmd_addr[ADDR_W-1 -: SECT_W];
        ph        <= EP_PRE;
        idx       <= '0;
      end else if (ers_run) begin
        case (ph)
          EP_PRE: begin
            idx <= idx + 1'b1;
            if (idx == IDX_LAST) begin
              ph   <= EP_WAIT;
              ecnt <= ECNT_INIT;
            end
          end
          EP_WAIT: begin
            if (ecnt == '0) ph <= EP_CLR;
            else ecnt <= ecnt - 1'b1;
          end
          default: begin
            idx <= idx + 1'b1;
            if (idx == IDX_LAST) erase_act <= 1'b0;
          end
        endcase
      end

      if (go_susp && erase_act) susp <= 1'b1;
      if (go_resume) susp <= 1'b0;
      if (ers_done) susp <= 1'b0;
    end
  end

  always_comb begin
    if (prog_act) mem_addr = op_addr;
    else if (ers_run) mem_addr = {esect, idx};
    else mem_addr = bus_addr;
  end

  assign mem_we = (prog_act && pcnt == '0) || (ers_run && !prog_act && ph != EP_WAIT);
  assign mem_wd = prog_act ? (mem_q & op_data) : ((ph == EP_CLR) ? 16'hFFFF : 16'h0000);
  assign exp7   = prog_act ? op_data[7] : 1'b1;
  assign status = {8'h00, ~exp7, tog, 6'h00};
endmodule

// File: rtl/norflash_cmd.sv
module norflash_cmd #(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 40,
  parameter bit WP_LAST   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  input  logic              wp_n,
  output logic              rdy
);
  logic              wr_lvl, rd_lvl, wr_q, rd_q, wr_evt, rd_evt;
  logic              go_prog, go_erase, go_susp, go_resume;
  logic [ADDR_W-1:0] cmd_addr, mem_addr;
  logic [15:0]       cmd_data, mem_wd, mem_q, status;
  logic              mem_we, busy, ers_run, susp, prog_act, erase_act;
  logic [SECT_W-1:0] esect;

  assign wr_lvl = !ce_n && !we_n;
  assign rd_lvl = !ce_n && !oe_n && we_n;
  assign wr_evt = wr_lvl && !wr_q;
  assign rd_evt = rd_lvl && !rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      rdy  <= 1'b1;
      dout <= '0;
    end else begin
      wr_q <= wr_lvl;
      rd_q <= rd_lvl;
      rdy  <= !busy;
      dout <= busy ? status : mem_q;
    end
  end

  norflash_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .WP_LAST(WP_LAST)) u_dec (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .addr(addr), .din(din), .wp_n(wp_n),
    .busy(busy), .ers_run(ers_run), .susp(susp), .esect(esect),
    .go_prog(go_prog), .go_erase(go_erase), .go_susp(go_susp), .go_resume(go_resume),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  norflash_engine #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
                    .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst(rst), .go_prog(go_prog), .go_erase(go_erase), .go_susp(go_susp),
    .go_resume(go_resume), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .bus_addr(addr),
    .rd_evt(rd_evt), .mem_q(mem_q), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wd(mem_wd), .busy(busy), .ers_run(ers_run), .susp(susp), .prog_act(prog_act),
    .erase_act(erase_act), .esect(esect), .status(status)
  );

  norflash_array #(.ADDR_W(ADDR_W), .DATA_W(16)) u_arr (
    .clk(clk), .addr(mem_addr), .we(mem_we), .wd(mem_wd), .rd(mem_q)
  );
endmodule

// File: rtl/norflash_chk.sv
module norflash_chk (
  input logic        clk,
  input logic        rst,
  input logic        rdy,
  input logic [15:0] dout,
  input logic        busy,
  input logic        prog_act,
  input logic        erase_act,
  input logic        susp
);
  // R1: reset leaves nothing running and the ready line high
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (rdy && !prog_act && !erase_act && !susp));

  // R3: an active program keeps the ready line low
  p_rdy_low_r3: assert property (@(posedge clk) disable iff (rst)
    (prog_act && $past(prog_act)) |-> !rdy);

  // R4: status word carries only bits 7 and 6
  p_status_bits_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (dout[15:8] == 8'h00 && dout[5:0] == 6'h00));

  // R7: a program never runs beside an unpaused erase
  p_one_op_r7: assert property (@(posedge clk) disable iff (rst)
    prog_act |-> !(erase_act && !susp));

  // R7: a pause only exists while an erase is pending
  p_susp_erase_r7: assert property (@(posedge clk) disable iff (rst)
    susp |-> erase_act);
endmodule

bind norflash_cmd norflash_chk u_chk (
  .clk(clk), .rst(rst), .rdy(rdy), .dout(dout), .busy(busy),
  .prog_act(prog_act), .erase_act(erase_act), .susp(susp)
);

// File: tb/norflash_cmd_bench.sv
module norflash_cmd_bench;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int NW    = 1 << AW;
  localparam int SWD   = 16;
  localparam logic [AW-1:0] U1 = 6'h15;
  localparam logic [AW-1:0] U2 = 6'h2A;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, wp_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   din = '0;
  logic [15:0]   dout;
  logic          rdy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model [NW];

  always #(CLK_P/2) clk = ~clk;

  norflash_cmd u_norflash_cmd (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .wp_n(wp_n), .rdy(rdy)
  );

  function automatic logic [15:0] pat(input int i, input int k);
    return 16'((i * 16'h02F1) ^ (k * 16'h5A3C) ^ 16'h0F0F);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(negedge clk);
    v = dout; oe_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(U1, 16'h00AA); wr(U2, 16'h0055);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    unlock(); wr(U1, 16'h00A0); wr(a, d);
  endtask

  task automatic erase(input logic [AW-1:0] a);
    unlock(); wr(U1, 16'h0080); unlock(); wr(a, 16'h0030);
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    repeat (4) @(negedge clk);
    while (rdy !== 1'b1 && n < 5000) begin @(negedge clk); n++; end
    chk(rdy === 1'b1, tag, {15'h0, rdy}, 16'h1);
  endtask

  task automatic wait_busy(input string tag);
    int n = 0;
    while (rdy !== 1'b0 && n < 20) begin @(negedge clk); n++; end
    chk(rdy === 1'b0, tag, {15'h0, rdy}, 16'h0);
  endtask

  task automatic verify_all(input string tag);
    logic [15:0] v;
    for (int i = 0; i < NW; i++) begin
      rd(AW'(i), v);
      chk(v === model[i], tag, v, model[i]);
    end
  endtask

  initial begin
    logic [15:0] v, v2;
    for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rdy === 1'b1, "R1 ready after reset", {15'h0, rdy}, 16'h1);
    verify_all("R1 erased at start");

    // R2 / R11: program every word, then clear more bits in a few
    for (int i = 0; i < NW; i++) begin
      prog(AW'(i), pat(i, 1));
      wait_done("R3 program ends");
      model[i] = model[i] & pat(i, 1);
    end
    verify_all("R2 program sweep");
    for (int i = 0; i < 8; i++) begin
      prog(AW'(i * 7), pat(i, 2));
      wait_done("R3 program ends");
      model[i * 7] = model[i * 7] & pat(i, 2);
    end
    verify_all("R11 and-only program");

    // R4: status during a program
    prog(6'd40, 16'h0055);
    wait_busy("R3 busy after program");
    rd(6'd40, v); rd(6'd40, v2);
    chk((v & 16'hFFBF) === 16'h0080, "R4 program status", v, 16'h0080);
    chk(v[6] !== v2[6], "R4 toggle", v2, v ^ 16'h0040);
    chk(rdy === 1'b0, "R3 still busy", {15'h0, rdy}, 16'h0);
    wait_done("R3 program ends");
    model[40] = model[40] & 16'h0055;
    rd(6'd40, v);
    chk(v === model[40], "R3 array after done", v, model[40]);

    // R5: erase sector 1, status during erase
    erase(6'h17);
    wait_busy("R5 erase busy");
    rd(6'd0, v); rd(6'd0, v2);
    chk((v & 16'hFFBF) === 16'h0000, "R4 erase status", v, 16'h0000);
    chk(v[6] !== v2[6], "R4 erase toggle", v2, v ^ 16'h0040);
    wait_done("R5 erase ends");
    for (int i = SWD; i < 2 * SWD; i++) model[i] = 16'hFFFF;
    verify_all("R5 sector erase");

    // R6: fast two-write program mode
    unlock(); wr(U1, 16'h0020);
    for (int i = SWD; i < 2 * SWD; i++) begin
      wr(6'd0, 16'h00A0); wr(AW'(i), pat(i, 3));
      wait_done("R6 fast program ends");
      model[i] = model[i] & pat(i, 3);
    end
    verify_all("R6 fast program");
    wr(6'd0, 16'h00F0);
    wr(6'd0, 16'h00A0); wr(6'd16, 16'h0000);
    wait_done("R6 exit");
    rd(6'd16, v);
    chk(v === model[16], "R6 lone A0 after exit", v, model[16]);

    // R8: write protect on sector 0
    wp_n = 1'b0;
    prog(6'd2, 16'h0000);
    repeat (4) @(negedge clk);
    chk(rdy === 1'b1, "R8 protected program stays ready", {15'h0, rdy}, 16'h1);
    erase(6'd1);
    repeat (4) @(negedge clk);
    chk(rdy === 1'b1, "R8 protected erase stays ready", {15'h0, rdy}, 16'h1);
    unlock(); wr(U1, 16'h0020); wr(6'd0, 16'h00A0); wr(6'd3, 16'h0000);
    wait_done("R8 fast program dropped");
    wr(6'd0, 16'h00F0);
    verify_all("R8 protected sector kept");
    wp_n = 1'b1;
    prog(6'd2, 16'h0000);
    wait_done("R8 unprotected program");
    model[2] = 16'h0000;
    rd(6'd2, v);
    chk(v === 16'h0000, "R8 program after release", v, 16'h0000);

    // R9: broken sequence
    wr(U1, 16'h00AA); wr(U2, 16'h0012); wr(U1, 16'h00A0); wr(6'd9, 16'h0000);
    repeat (4) @(negedge clk);
    chk(rdy === 1'b1, "R9 no operation", {15'h0, rdy}, 16'h1);
    rd(6'd9, v);
    chk(v === model[9], "R9 word unchanged", v, model[9]);
    wr(U1, 16'h00AA); wr(U2, 16'h00F0); wr(6'd10, 16'h0000);
    rd(6'd10, v);
    chk(v === model[10], "R9 reset code mid sequence", v, model[10]);

    // R10: writes while busy
    prog(6'd7, 16'h0F00);
    wait_busy("R10 busy");
    prog(6'd8, 16'h0000);
    wait_done("R10 done");
    model[7] = model[7] & 16'h0F00;
    rd(6'd7, v);
    chk(v === model[7], "R10 first program", v, model[7]);
    rd(6'd8, v);
    chk(v === model[8], "R10 ignored program", v, model[8]);

    // R7: pause and resume erase of sector 2
    erase(6'h21);
    wait_busy("R7 erase busy");
    wr(6'd0, 16'h00B0);
    repeat (4) @(negedge clk);
    chk(rdy === 1'b1, "R7 paused ready", {15'h0, rdy}, 16'h1);
    rd(6'd18, v);
    chk(v === model[18], "R7 read other sector", v, model[18]);
    prog(6'h30, 16'h1111);
    wait_done("R7 program while paused");
    model[48] = model[48] & 16'h1111;
    rd(6'h30, v);
    chk(v === model[48], "R7 program other sector", v, model[48]);
    prog(6'h22, 16'h0000);
    repeat (4) @(negedge clk);
    chk(rdy === 1'b1, "R7 paused sector program dropped", {15'h0, rdy}, 16'h1);
    wr(6'd0, 16'h0030);
    wait_busy("R7 resumed busy");
    wait_done("R7 erase completes");
    for (int i = 2 * SWD; i < 3 * SWD; i++) model[i] = 16'hFFFF;
    verify_all("R7 after resume");

    // R1: reset aborts a program
    prog(6'd5, 16'h0000);
    wait_busy("R1 busy before reset");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(rdy === 1'b1, "R1 ready after abort", {15'h0, rdy}, 16'h1);
    rd(6'd5, v);
    chk(v === model[5], "R1 aborted word kept", v, model[5]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule